// File: doc/BRIEF.md
# Low-Power Run Mode Controller

This controller decides when a microcontroller may drop its voltage regulator into standby while the CPU keeps running, and when it must return to full regulation. Software holds two control bits: a low-power request and a wake-on-interrupt enable. It writes both bits together through a single write strobe. Entry happens only when the request is set and every hardware permission qualifier is true. Entry is also refused while a debugger holds the core in background mode, or when the boot level sampled at reset selected debug start-up.

Low-power operation can end in three ways. Software can clear its request bit. If the pin exit is enabled, a falling edge on the asynchronous mode pin ends it. If wake-on-interrupt is enabled, a pending interrupt ends it. A pin or interrupt exit leaves the software request bit set. The controller then stays in full regulation until software clears the request bit and sets it again. A read-only status output reports whether the regulator is in reduced regulation. This output is low whenever full-speed operation is allowed.

Top module: `lp_run_ctrl`

## Requirements
- R1: `boot_run` captures the level of `mode_pin` on the first clock edge after `rst_n` rises (1 = normal run). While `boot_run` is 0, low-power entry never happens.
- R2: `stby_req` rises on the clock edge after the one where the request bit is held at 1, and only when every bit of `perm_ok` is 1. The bit order is: [0] bus clock below 125 kHz, [1] high-gain oscillator off, [2] ADC in low-power mode or off, [3] low-voltage detect off, [4] no flash program or erase.
- R3: While `dbg_active` is 1, `stby_req` does not rise.
- R4: When `lp_req_bit` reads 0 during low-power run, `lp_status` is 0 in that same cycle and `stby_req` falls on the next edge.
- R5: `lp_status` becomes 1 one cycle after `stby_req` rises. It is never 1 while `stby_req` is 0.
- R6: With `pin_exit_en` = 1, a falling edge on `mode_pin` during low-power run clears `lp_status` after the synchronizer delay (SYNC_STAGES edges) and drops `stby_req` one edge later. `lp_req_bit` stays 1. With `pin_exit_en` = 0, the edge has no effect.
- R7: With the wake bit at 1, `irq_pend` during low-power run clears `lp_status` in the same cycle and drops `stby_req` on the next edge. With the wake bit at 0, `irq_pend` has no effect.
- R8: After a pin or interrupt exit, the controller does not re-enter low-power run until the request bit has read 0 and then been set again.
- R9: Reset leaves `stby_req`, `lp_status`, `lp_req_bit` and `wake_en_bit` all at 0.
- R10: A cycle with `reg_wr` = 1 loads `wr_lp_req` and `wr_wake_en` into the two control bits, and they read back on `lp_req_bit` and `wake_en_bit` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low internal reset |
| reg_wr | input | 1 | Control register write strobe |
| wr_lp_req | input | 1 | Write data for the low-power request bit |
| wr_wake_en | input | 1 | Write data for the wake-on-interrupt bit |
| perm_ok | input | NUM_QUAL | Entry permission qualifiers, all must be 1 |
| dbg_active | input | 1 | Background debug mode is active |
| mode_pin | input | 1 | Asynchronous debug/mode pin |
| pin_exit_en | input | 1 | Enables exit on a falling edge of the pin |
| irq_pend | input | 1 | Any interrupt is pending |
| lp_req_bit | output | 1 | Read-back of the low-power request bit |
| wake_en_bit | output | 1 | Read-back of the wake-on-interrupt bit |
| boot_run | output | 1 | Boot level sampled after reset |
| stby_req | output | 1 | Regulator standby request |
| lp_status | output | 1 | Read-only reduced-regulation status |

## Verification
The hardest state to reach is the one after a pin or interrupt exit. Here the request bit is still set and every qualifier is still true, yet the controller must stay in full regulation. The stimulus reaches this state by first entering low-power run, then driving the pin low, and counting the synchronizer edges to see when the status falls. It then holds all entry conditions true for several cycles and confirms that no re-entry occurs. Finally it clears the request bit and sets it again. An exhaustive sweep over all 32 qualifier patterns, each with the debug flag both low and high, covers the entry gating.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   typedef enum logic [1:0] {
      EXIT_NONE = 2'd0,
      EXIT_SW   = 2'd1,
      EXIT_PIN  = 2'd2,
      EXIT_IRQ  = 2'd3
   } exit_cause_e;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpr_gate.sv
module lpr_gate #(
   parameter int NUM_QUAL = 5
) (
   input  logic [NUM_QUAL-1:0] perm_ok,
   input  logic                dbg_active,
   input  logic                boot_run,
   output logic                entry_ok
);
   logic [NUM_QUAL:0] acc;

   assign acc[0] = 1'b1;
   for (genvar i = 0; i < NUM_QUAL; i++) begin : g_qual
      assign acc[i+1] = acc[i] & perm_ok[i];
   end

   assign entry_ok = acc[NUM_QUAL] & ~dbg_active & boot_run;
endmodule

// File: rtl/lpr_core.sv
module lpr_core
   import lpr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lpr,
   input  logic wake,
   input  logic entry_ok,
   input  logic pin_fall,
   input  logic pin_exit_en,
   input  logic irq_pend,
   output logic stby,
   output logic status
);
   logic        stby_q, stat_q, armed_q;
   exit_cause_e cause;

   always_comb begin
      cause = EXIT_NONE;
      if (stby_q) begin
         if (!lpr)                        cause = EXIT_SW;
         else if (pin_exit_en && pin_fall) cause = EXIT_PIN;
         else if (wake && irq_pend)       cause = EXIT_IRQ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby_q  <= 1'b0;
         stat_q  <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         if (cause != EXIT_NONE)
            stby_q <= 1'b0;
         else if (!stby_q && lpr && armed_q && entry_ok)
            stby_q <= 1'b1;
         stat_q <= stby_q && (cause == EXIT_NONE);
         if (cause == EXIT_PIN || cause == EXIT_IRQ) armed_q <= 1'b0;
         else if (!lpr)                              armed_q <= 1'b1;
      end
   end

   assign stby   = stby_q;
   assign status = stat_q && (cause == EXIT_NONE);
endmodule

// File: rtl/lp_run_ctrl.sv
module lp_run_ctrl #(
   parameter int NUM_QUAL    = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_IDLE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                wr_lp_req,
   input  logic                wr_wake_en,
   input  logic [NUM_QUAL-1:0] perm_ok,
   input  logic                dbg_active,
   input  logic                mode_pin,
   input  logic                pin_exit_en,
   input  logic                irq_pend,
   output logic                lp_req_bit,
   output logic                wake_en_bit,
   output logic                boot_run,
   output logic                stby_req,
   output logic                lp_status
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NUM_QUAL < 1) begin : g_bad_qual
      $error("NUM_QUAL must be at least 1");
   end

   logic lpr_q, wake_q, boot_seen_q, boot_q;
   logic pin_s, pin_prev_q, pin_fall, entry_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lpr_q  <= 1'b0;
         wake_q <= 1'b0;
      end else if (reg_wr) begin
         lpr_q  <= wr_lp_req;
         wake_q <= wr_wake_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_seen_q <= 1'b0;
         boot_q      <= 1'b0;
      end else if (!boot_seen_q) begin
         boot_seen_q <= 1'b1;
         boot_q      <= mode_pin;
      end
   end

   lpr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(mode_pin), .q(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev_q <= PIN_IDLE;
      else        pin_prev_q <= pin_s;
   end
   assign pin_fall = pin_prev_q & ~pin_s;

   lpr_gate #(.NUM_QUAL(NUM_QUAL)) gate_i (
      .perm_ok(perm_ok), .dbg_active(dbg_active), .boot_run(boot_q),
      .entry_ok(entry_ok)
   );

   lpr_core core_i (
      .clk(clk), .rst_n(rst_n), .lpr(lpr_q), .wake(wake_q),
      .entry_ok(entry_ok), .pin_fall(pin_fall), .pin_exit_en(pin_exit_en),
      .irq_pend(irq_pend), .stby(stby_req), .status(lp_status)
   );

   assign lp_req_bit  = lpr_q;
   assign wake_en_bit = wake_q;
   assign boot_run    = boot_q;
endmodule

// File: rtl/lp_run_ctrl_chk.sv
module lp_run_ctrl_chk #(
   parameter int NUM_QUAL = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic                lpr,
   input logic                wake,
   input logic                stby,
   input logic                status,
   input logic [NUM_QUAL-1:0] perm_ok,
   input logic                dbg_active,
   input logic                pin_exit_en,
   input logic                pin_fall,
   input logic                irq_pend
);
   a_r2_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stby) |-> ($past(&perm_ok) && $past(lpr)));
   a_r3_debug_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_active && !stby) |=> !stby);
   a_r4_sw_exit_status: assert property (@(posedge clk) disable iff (!rst_n)
      (stby && !lpr) |-> !status);
   a_r4_sw_exit_stby: assert property (@(posedge clk) disable iff (!rst_n)
      (stby && !lpr) |=> !stby);
   a_r5_status_needs_stby: assert property (@(posedge clk) disable iff (!rst_n)
      status |-> stby);
   a_r5_status_lags: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stby) |-> !status);
   a_r6_pin_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (stby && pin_exit_en && pin_fall && !reg_wr) |=> (!stby && lpr));
   a_r7_irq_status: assert property (@(posedge clk) disable iff (!rst_n)
      (stby && wake && irq_pend) |-> !status);
   a_r7_irq_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (stby && wake && irq_pend) |=> !stby);
endmodule

bind lp_run_ctrl lp_run_ctrl_chk #(.NUM_QUAL(NUM_QUAL)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .lpr(lpr_q), .wake(wake_q),
   .stby(stby_req), .status(lp_status), .perm_ok(perm_ok),
   .dbg_active(dbg_active), .pin_exit_en(pin_exit_en), .pin_fall(pin_fall),
   .irq_pend(irq_pend)
);

// File: tb/lp_run_ctrl_tb_top.sv
module lp_run_ctrl_tb_top;
   localparam int NQ = 5;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, wr_lp_req = 1'b0, wr_wake_en = 1'b0;
   logic [NQ-1:0] perm_ok = '0;
   logic dbg_active = 1'b0, mode_pin = 1'b1, pin_exit_en = 1'b0, irq_pend = 1'b0;
   logic lp_req_bit, wake_en_bit, boot_run, stby_req, lp_status;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lp_run_ctrl #(.NUM_QUAL(NQ), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_lp_req(wr_lp_req),
      .wr_wake_en(wr_wake_en), .perm_ok(perm_ok), .dbg_active(dbg_active),
      .mode_pin(mode_pin), .pin_exit_en(pin_exit_en), .irq_pend(irq_pend),
      .lp_req_bit(lp_req_bit), .wake_en_bit(wake_en_bit), .boot_run(boot_run),
      .stby_req(stby_req), .lp_status(lp_status)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic l, input logic w);
      @(negedge clk); reg_wr = 1'b1; wr_lp_req = l; wr_wake_en = w;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic do_reset(input logic pin);
      @(negedge clk); rst_n = 1'b0; mode_pin = pin;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic enter_lp(input logic w);
      perm_ok = '1; dbg_active = 1'b0;
      wr(1'b1, w);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset(1'b1);
      chk("R9 stby", stby_req, 0);
      chk("R9 status", lp_status, 0);
      chk("R9 lpr", lp_req_bit, 0);
      chk("R9 wake", wake_en_bit, 0);
      chk("R1 boot high", boot_run, 1);

      wr(1'b1, 1'b0);
      chk("R10 lpr readback", lp_req_bit, 1);
      chk("R10 wake readback", wake_en_bit, 0);
      wr(1'b0, 1'b1);
      chk("R10 lpr cleared", lp_req_bit, 0);
      chk("R10 wake set", wake_en_bit, 1);
      wr(1'b0, 1'b0);

      // R2 / R3: exhaustive qualifier and debug sweep
      for (int q = 0; q < 32; q++) begin
         for (int b = 0; b < 2; b++) begin
            int exp_lp;
            perm_ok = q[NQ-1:0]; dbg_active = b[0];
            exp_lp = (q == 31 && b == 0) ? 1 : 0;
            wr(1'b1, 1'b0);
            @(negedge clk);
            chk(b ? "R3 stby gated" : "R2 stby gated", stby_req, exp_lp);
            chk("R5 status lags", lp_status, 0);
            @(negedge clk);
            chk("R5 status set", lp_status, exp_lp);
            wr(1'b0, 1'b0);
            @(negedge clk);
            chk("R4 stby off", stby_req, 0);
         end
      end
      dbg_active = 1'b0;

      // R4 exit timing
      enter_lp(1'b0);
      chk("R4 in lp", lp_status, 1);
      wr(1'b0, 1'b0);
      chk("R4 status same cycle", lp_status, 0);
      chk("R4 stby one later", stby_req, 1);
      @(negedge clk);
      chk("R4 stby dropped", stby_req, 0);

      // R6 pin exit, then R8 no re-entry
      pin_exit_en = 1'b1;
      enter_lp(1'b0);
      mode_pin = 1'b0;
      @(negedge clk);
      chk("R6 sync delay", lp_status, 1);
      @(negedge clk);
      chk("R6 status cleared", lp_status, 0);
      chk("R6 stby held", stby_req, 1);
      @(negedge clk);
      chk("R6 stby dropped", stby_req, 0);
      chk("R6 lpr stays", lp_req_bit, 1);
      repeat (5) @(negedge clk);
      mode_pin = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 no reentry pin", stby_req, 0);
      wr(1'b0, 1'b0);
      wr(1'b1, 1'b0);
      @(negedge clk);
      chk("R8 reentry after rearm", stby_req, 1);

      // R6 disabled pin edge
      pin_exit_en = 1'b0;
      @(negedge clk); mode_pin = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 disabled stby", stby_req, 1);
      chk("R6 disabled status", lp_status, 1);
      mode_pin = 1'b1;
      repeat (3) @(negedge clk);
      wr(1'b0, 1'b0);
      @(negedge clk);

      // R7 interrupt exit
      enter_lp(1'b1);
      chk("R7 in lp", lp_status, 1);
      irq_pend = 1'b1;
      #1;
      chk("R7 status same cycle", lp_status, 0);
      chk("R7 stby held", stby_req, 1);
      @(negedge clk);
      chk("R7 stby dropped", stby_req, 0);
      irq_pend = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 no reentry irq", stby_req, 0);
      wr(1'b0, 1'b1);
      wr(1'b1, 1'b1);
      @(negedge clk);
      chk("R8 reentry irq", stby_req, 1);
      wr(1'b1, 1'b0);
      irq_pend = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 wake off stby", stby_req, 1);
      chk("R7 wake off status", lp_status, 1);
      irq_pend = 1'b0;
      wr(1'b0, 1'b0);
      @(negedge clk);

      // R1 boot low blocks entry
      do_reset(1'b0);
      chk("R1 boot low", boot_run, 0);
      mode_pin = 1'b1;
      enter_lp(1'b0);
      chk("R1 entry blocked", stby_req, 0);
      do_reset(1'b1);
      chk("R1 boot high again", boot_run, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule